// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches received Ethernet frames, presented one byte per cycle with start, valid and end markers, and decides whether a frame is a wake-up Magic Packet. A qualifying frame carries an acceptable destination address. Somewhere after the 14-byte header, its payload holds a synchronization run of 0xFF bytes followed by sixteen back-to-back copies of the station's 48-bit address. The frame counts only if the link layer reports it good at its end.

The destination rule is selectable. The strict rule demands the station address exactly. The relaxed rule takes any unicast, multicast or broadcast destination and is enabled by either of two separate control bits. A small control register holds the enable, mode, interrupt-enable and relaxed-address bits. A sticky wake flag records a detection and is cleared by writing 1 to it. The interrupt output is the flag gated by its own enable and by a chip-wide interrupt enable. Detection runs only while the detection mode is active. The mode needs the mode bit together with either the enable bit or, in the power-good variant, an external power-good input.

Top module: `wol_detector`

## Requirements
- R1: With the relaxed rule off, a frame qualifies only if its first six bytes equal the station address, compared least significant byte first (frame byte 0 against `station_addr[7:0]`). A differing unicast address or a broadcast address does not set the flag.
- R2: With control bit 3 or the `relax_ext` input at 1, a unicast, multicast or broadcast destination is accepted.
- R3: Under either destination rule, the payload (frame byte 14 onward) must hold six 0xFF bytes followed by exactly sixteen consecutive copies of the station address. Fifteen copies, or one corrupted byte, do not qualify.
- R4: A mismatching byte restarts the search, and a 0xFF that breaks a partial match counts as the first byte of a new synchronization run. Extra 0xFF bytes between a complete synchronization run and the first address copy are tolerated.
- R5: A detection counts only if `rx_good` is 1 on the end byte. A new start marker in mid-frame discards any partial or complete match.
- R6: With `PG_ENTRY`=1, the detection mode is active when the mode bit (control bit 1) is 1 and either the enable bit (bit 0) or `pwr_good` is 1. With `PG_ENTRY`=0, the mode needs both bits.
- R7: The wake flag rises in the cycle after the end byte of a qualifying frame.
- R8: A control write with bit 4 at 1 clears the flag, and a write with bit 4 at 0 leaves it unchanged. If a clear and a new detection fall in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly when the flag, the interrupt-enable bit (control bit 2) and `glb_ie` are all 1.
- R10: Reset and `sw_reset` clear all control bits and the flag. `stop_cmd` clears only the flag and leaves the control bits as they were.
- R11: While the detection mode is inactive, a qualifying frame leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset |
| stop_cmd | input | 1 | Stop command; clears the wake flag |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_good | input | 1 | Frame good, sampled with the last byte |
| rx_data | input | 8 | Receive byte |
| station_addr | input | 48 | Station address, byte 0 sent first |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Bits 3:0 control bits; bit 4 write-1 flag clear |
| relax_ext | input | 1 | Second relaxed-address control bit |
| pwr_good | input | 1 | External power-good |
| glb_ie | input | 1 | Chip-wide interrupt enable |
| ctl_bits | output | 4 | Control bits {relaxed, int enable, mode, enable} |
| mode_active | output | 1 | Detection mode active |
| wake_flag | output | 1 | Sticky Magic Packet detected flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `rx_eof` and `rx_good` are meaningful only on a valid byte. They also assume that the flag can rise only after a valid, good end byte seen while the mode was active. The stimulus therefore drives `rx_good` only together with the end byte, and drives the frame markers only with `rx_valid`. Control writes, stop and software reset are each held for a single cycle, away from frame ends, except in the one test that deliberately places a clear on the end byte to check which of the two wins.

// File: rtl/wol_pkg.sv
`timescale 1ns/1ps
package wol_pkg;
    localparam int BYTE_W      = 8;
    localparam int MAC_BYTES   = 6;
    localparam int HDR_BYTES   = 14;
    localparam int SYNC_BYTES  = 6;
    localparam int ADDR_COPIES = 16;
    localparam logic [BYTE_W-1:0] SYNC_VAL = 8'hFF;

    // control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_IE    = 2;
    localparam int CB_RELAX = 3;
    localparam int CB_CLR   = 4;
    localparam int CTL_W    = 5;

    // packed so that field order matches the CB_* positions
    typedef struct packed {
        logic relax;
        logic ie;
        logic mode;
        logic en;
    } ctl_bits_t;
endpackage

// File: rtl/wol_dest_check.sv
`timescale 1ns/1ps
// Tracks the byte position inside a frame and compares the destination field.
module wol_dest_check #(
    parameter int BYTE_W    = wol_pkg::BYTE_W,
    parameter int MAC_BYTES = wol_pkg::MAC_BYTES,
    parameter int HDR_BYTES = wol_pkg::HDR_BYTES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          rx_valid,
    input  logic                          rx_sof,
    input  logic                          rx_eof,
    input  logic [BYTE_W-1:0]             rx_data,
    input  logic [MAC_BYTES*BYTE_W-1:0]   station_addr,
    output logic                          byte_ok,
    output logic                          frame_end,
    output logic                          payload_byte,
    output logic                          dest_hit
);
    localparam int IDX_W = $clog2(HDR_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic             match;
    } dst_st_t;

    dst_st_t          st_d, st_q;
    logic [IDX_W-1:0] cur_idx;
    logic             cur_match;

    always_comb begin
        st_d      = st_q;
        byte_ok   = rx_valid && (rx_sof || st_q.active);
        cur_idx   = rx_sof ? '0 : st_q.idx;
        cur_match = rx_sof ? 1'b1 : st_q.match;
        if (byte_ok) begin
            for (int i = 0; i < MAC_BYTES; i++) begin
                if (cur_idx == IDX_W'(i) &&
                    rx_data != station_addr[i*BYTE_W +: BYTE_W]) begin
                    cur_match = 1'b0;
                end
            end
            st_d.active = !rx_eof;
            st_d.idx    = (cur_idx == IDX_LAST) ? cur_idx : cur_idx + 1'b1;
            st_d.match  = cur_match;
        end
        if (clr) begin
            st_d = '0;
        end
        frame_end    = byte_ok && rx_eof;
        payload_byte = byte_ok && (cur_idx == IDX_LAST);
        dest_hit     = cur_match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wol_pattern_scan.sv
`timescale 1ns/1ps
// Searches the payload for a sync run followed by repeated station address copies.
module wol_pattern_scan #(
    parameter int                BYTE_W      = wol_pkg::BYTE_W,
    parameter int                MAC_BYTES   = wol_pkg::MAC_BYTES,
    parameter int                SYNC_BYTES  = wol_pkg::SYNC_BYTES,
    parameter int                ADDR_COPIES = wol_pkg::ADDR_COPIES,
    parameter logic [BYTE_W-1:0] SYNC_VAL    = wol_pkg::SYNC_VAL
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        restart,
    input  logic                        scan_en,
    input  logic [BYTE_W-1:0]           rx_data,
    input  logic [MAC_BYTES*BYTE_W-1:0] station_addr,
    output logic                        found
);
    localparam int SY_W = $clog2(SYNC_BYTES + 1);
    localparam int PS_W = $clog2(MAC_BYTES);
    localparam int CP_W = $clog2(ADDR_COPIES + 1);
    localparam logic [SY_W-1:0] SYNC_FULL = SY_W'(SYNC_BYTES);
    localparam logic [SY_W-1:0] SYNC_ONE  = SY_W'(1);
    localparam logic [PS_W-1:0] POS_LAST  = PS_W'(MAC_BYTES - 1);
    localparam logic [CP_W-1:0] CP_LAST   = CP_W'(ADDR_COPIES - 1);

    typedef struct packed {
        logic [SY_W-1:0] sync;
        logic [PS_W-1:0] pos;
        logic [CP_W-1:0] copies;
        logic            found;
    } scan_st_t;

    scan_st_t          st_d, st_q, base;
    logic [BYTE_W-1:0] exp_byte;
    logic              is_sync;

    always_comb begin
        base = restart ? '0 : st_q;
        st_d = base;
        exp_byte = '0;
        for (int i = 0; i < MAC_BYTES; i++) begin
            if (base.pos == PS_W'(i)) begin
                exp_byte = station_addr[i*BYTE_W +: BYTE_W];
            end
        end
        is_sync = (rx_data == SYNC_VAL);
        if (scan_en && !base.found) begin
            if (base.sync != SYNC_FULL) begin
                st_d.sync = is_sync ? base.sync + 1'b1 : '0;
            end else if (rx_data == exp_byte) begin
                if (base.pos == POS_LAST) begin
                    st_d.pos    = '0;
                    st_d.copies = base.copies + 1'b1;
                    if (base.copies == CP_LAST) begin
                        st_d.found = 1'b1;
                    end
                end else begin
                    st_d.pos = base.pos + 1'b1;
                end
            end else if (is_sync && base.pos == '0 && base.copies == '0) begin
                st_d = base;  // longer sync run before the first copy
            end else begin
                st_d.pos    = '0;
                st_d.copies = '0;
                st_d.sync   = is_sync ? SYNC_ONE : '0;
            end
        end
        if (clr) begin
            st_d = '0;
        end
        found = st_d.found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wol_irq_ctrl.sv
`timescale 1ns/1ps
// Control bits, detection mode gating, sticky wake flag and interrupt gating.
module wol_irq_ctrl
    import wol_pkg::*;
#(
    parameter bit PG_ENTRY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             stop_cmd,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             relax_ext,
    input  logic             pwr_good,
    input  logic             glb_ie,
    input  logic             frame_hit,
    output ctl_bits_t        ctl_bits,
    output logic             mode_active,
    output logic             relaxed,
    output logic             wake_flag,
    output logic             irq
);
    typedef struct packed {
        ctl_bits_t ctl;
        logic      flag;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     entry_alt;

    generate
        if (PG_ENTRY) begin : g_pg_entry
            assign entry_alt = st_q.ctl.en | pwr_good;
        end else begin : g_strict_entry
            logic unused_pg;
            assign unused_pg = pwr_good;
            assign entry_alt = st_q.ctl.en;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl = ctl_bits_t'(ctl_wdata[CB_RELAX:CB_EN]);
            if (ctl_wdata[CB_CLR]) begin
                st_d.flag = 1'b0;
            end
        end
        if (frame_hit) begin
            st_d.flag = 1'b1;
        end
        if (stop_cmd) begin
            st_d.flag = 1'b0;
        end
        if (sw_reset) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_bits    = st_q.ctl;
    assign mode_active = st_q.ctl.mode & entry_alt;
    assign relaxed     = st_q.ctl.relax | relax_ext;
    assign wake_flag   = st_q.flag;
    assign irq         = st_q.flag & st_q.ctl.ie & glb_ie;
endmodule

// File: rtl/wol_detector.sv
`timescale 1ns/1ps
module wol_detector
    import wol_pkg::*;
#(
    parameter bit PG_ENTRY    = 1'b1,
    parameter int MAC_BYTES   = wol_pkg::MAC_BYTES,
    parameter int HDR_BYTES   = wol_pkg::HDR_BYTES,
    parameter int SYNC_BYTES  = wol_pkg::SYNC_BYTES,
    parameter int ADDR_COPIES = wol_pkg::ADDR_COPIES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_reset,
    input  logic                        stop_cmd,
    input  logic                        rx_valid,
    input  logic                        rx_sof,
    input  logic                        rx_eof,
    input  logic                        rx_good,
    input  logic [BYTE_W-1:0]           rx_data,
    input  logic [MAC_BYTES*BYTE_W-1:0] station_addr,
    input  logic                        ctl_wr,
    input  logic [CTL_W-1:0]            ctl_wdata,
    input  logic                        relax_ext,
    input  logic                        pwr_good,
    input  logic                        glb_ie,
    output logic [3:0]                  ctl_bits,
    output logic                        mode_active,
    output logic                        wake_flag,
    output logic                        irq
);
    logic      clr;
    logic      byte_ok;
    logic      frame_end;
    logic      payload_byte;
    logic      dest_hit;
    logic      found;
    logic      relaxed;
    logic      frame_hit;
    ctl_bits_t ctl_q;

    assign clr = sw_reset | stop_cmd;

    wol_dest_check #(
        .BYTE_W    (BYTE_W),
        .MAC_BYTES (MAC_BYTES),
        .HDR_BYTES (HDR_BYTES)
    ) i_dest (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .byte_ok      (byte_ok),
        .frame_end    (frame_end),
        .payload_byte (payload_byte),
        .dest_hit     (dest_hit)
    );

    wol_pattern_scan #(
        .BYTE_W      (BYTE_W),
        .MAC_BYTES   (MAC_BYTES),
        .SYNC_BYTES  (SYNC_BYTES),
        .ADDR_COPIES (ADDR_COPIES),
        .SYNC_VAL    (SYNC_VAL)
    ) i_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .restart      (byte_ok && rx_sof),
        .scan_en      (payload_byte),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .found        (found)
    );

    assign frame_hit = frame_end && rx_good && (dest_hit || relaxed) &&
                       found && mode_active;

    wol_irq_ctrl #(
        .PG_ENTRY (PG_ENTRY)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .stop_cmd    (stop_cmd),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .relax_ext   (relax_ext),
        .pwr_good    (pwr_good),
        .glb_ie      (glb_ie),
        .frame_hit   (frame_hit),
        .ctl_bits    (ctl_q),
        .mode_active (mode_active),
        .relaxed     (relaxed),
        .wake_flag   (wake_flag),
        .irq         (irq)
    );

    assign ctl_bits = ctl_q;
endmodule

// File: rtl/wol_detector_chk.sv
`timescale 1ns/1ps
module wol_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_reset,
    input logic       stop_cmd,
    input logic       rx_valid,
    input logic       rx_eof,
    input logic       rx_good,
    input logic       ctl_wr,
    input logic       clr_req,
    input logic       glb_ie,
    input logic [3:0] ctl_bits,
    input logic       mode_active,
    input logic       wake_flag,
    input logic       irq
);
    // R7: the flag only rises right after a good end byte seen in detection mode
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(rx_valid && rx_eof && rx_good && mode_active));

    // R8: without a write-1 clear, stop or software reset the flag holds
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !(ctl_wr && clr_req) && !stop_cmd && !sw_reset) |=> wake_flag);

    // R9: no interrupt without the flag and the chip-wide enable
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wake_flag && glb_ie));

    // R10: stop clears the flag and leaves the control bits alone
    p_stop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !wake_flag);
    p_stop_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !sw_reset && !ctl_wr) |=> $stable(ctl_bits));

    // R10: software reset clears everything
    p_sw_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (ctl_bits == 4'b0000 && !wake_flag));

    // R6: the mode needs the mode bit
    p_mode_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_active |-> ctl_bits[1]);

    // R11: outside detection mode a clear flag stays clear
    p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_active && !wake_flag) |=> !wake_flag);
endmodule

bind wol_detector wol_detector_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .stop_cmd    (stop_cmd),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .rx_good     (rx_good),
    .ctl_wr      (ctl_wr),
    .clr_req     (ctl_wdata[wol_pkg::CB_CLR]),
    .glb_ie      (glb_ie),
    .ctl_bits    (ctl_bits),
    .mode_active (mode_active),
    .wake_flag   (wake_flag),
    .irq         (irq)
);

// File: tb/test_wol_detector.sv
`timescale 1ns/1ps
module test_wol_detector;
    localparam logic [47:0] STA   = 48'h1234_5678_9ABC;
    localparam logic [47:0] OTHER = 48'h1234_5678_9ABE;
    localparam logic [47:0] MCAST = 48'h3300_5E00_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0, stop_cmd = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        ctl_wr = 1'b0;
    logic [4:0]  ctl_wdata = 5'b0;
    logic        relax_ext = 1'b0, pwr_good = 1'b0, glb_ie = 1'b0;
    logic [3:0]  ctl_bits;
    logic        mode_active, wake_flag, irq;

    always #2 clk = ~clk;  // 250 MHz

    wol_detector i_wol_detector (
        .clk (clk), .rst_n (rst_n), .sw_reset (sw_reset), .stop_cmd (stop_cmd),
        .rx_valid (rx_valid), .rx_sof (rx_sof), .rx_eof (rx_eof), .rx_good (rx_good),
        .rx_data (rx_data), .station_addr (STA), .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata),
        .relax_ext (relax_ext), .pwr_good (pwr_good), .glb_ie (glb_ie),
        .ctl_bits (ctl_bits), .mode_active (mode_active), .wake_flag (wake_flag), .irq (irq)
    );

    typedef struct packed {
        logic [1:0] dest;    // 0 station, 1 broadcast, 2 other unicast, 3 multicast
        logic       relax;
        logic [3:0] nff;
        logic [4:0] ncopy;
        logic [7:0] bad;     // corrupted copy byte index, 255 = none
        logic       pre;     // partial match broken by the first sync byte
        logic       good;
        logic       hit;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b1},  // R1 R3 exact frame
        '{2'd2, 1'b0, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b0},  // R1 other unicast
        '{2'd1, 1'b0, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b0},  // R1 broadcast, strict
        '{2'd2, 1'b1, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b1},  // R2 unicast relaxed
        '{2'd1, 1'b1, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b1},  // R2 broadcast relaxed
        '{2'd3, 1'b1, 4'd6, 5'd16, 8'd255, 1'b0, 1'b1, 1'b1},  // R2 multicast relaxed
        '{2'd0, 1'b0, 4'd6, 5'd15, 8'd255, 1'b0, 1'b1, 1'b0},  // R3 fifteen copies
        '{2'd0, 1'b0, 4'd6, 5'd16, 8'd40,  1'b0, 1'b1, 1'b0},  // R3 corrupt byte
        '{2'd2, 1'b1, 4'd6, 5'd16, 8'd90,  1'b0, 1'b1, 1'b0},  // R3 corrupt, relaxed
        '{2'd0, 1'b0, 4'd6, 5'd16, 8'd255, 1'b1, 1'b1, 1'b1},  // R4 resync on 0xFF
        '{2'd0, 1'b0, 4'd5, 5'd16, 8'd255, 1'b0, 1'b1, 1'b0},  // R4 short sync run
        '{2'd0, 1'b0, 4'd8, 5'd16, 8'd255, 1'b0, 1'b1, 1'b1},  // R4 long sync run
        '{2'd0, 1'b0, 4'd6, 5'd16, 8'd255, 1'b0, 1'b0, 1'b0}   // R5 bad frame
    };

    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] fb [0:255];
    int         flen = 0;
    logic [3:0] ctl_cur = 4'b0;
    logic       flag_at_eof = 1'b0;

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build(input logic [1:0] dest, input logic [3:0] nff,
                         input logic [4:0] ncopy, input logic [7:0] bad, input logic pre);
        int p = 0;
        for (int i = 0; i < 6; i++) begin
            case (dest)
                2'd0:    fb[p] = STA[i*8 +: 8];
                2'd1:    fb[p] = 8'hFF;
                2'd2:    fb[p] = OTHER[i*8 +: 8];
                default: fb[p] = MCAST[i*8 +: 8];
            endcase
            p++;
        end
        for (int i = 0; i < 6; i++) begin fb[p] = 8'h20 + 8'(i); p++; end
        fb[p] = 8'h08; p++;
        fb[p] = 8'h42; p++;
        for (int i = 0; i < 3; i++) begin fb[p] = 8'h11; p++; end
        if (pre) begin
            for (int i = 0; i < 6; i++) begin fb[p] = 8'hFF; p++; end
            for (int i = 0; i < 9; i++) begin fb[p] = STA[(i % 6)*8 +: 8]; p++; end
        end
        for (int i = 0; i < int'(nff); i++) begin fb[p] = 8'hFF; p++; end
        for (int c = 0; c < int'(ncopy); c++) begin
            for (int i = 0; i < 6; i++) begin
                fb[p] = STA[i*8 +: 8] ^ ((c*6 + i == int'(bad)) ? 8'h01 : 8'h00);
                p++;
            end
        end
        for (int i = 0; i < 4; i++) begin fb[p] = 8'h00; p++; end
        flen = p;
    endtask

    task automatic send(input logic good, input logic do_eof, input logic clr_at_eof);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            if (i == 20) begin
                rx_valid = 1'b0; rx_sof = 1'b0;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = do_eof && (i == flen - 1);
            rx_good  = good && rx_eof;
            rx_data  = fb[i];
            if (rx_eof) begin
                flag_at_eof = wake_flag;
                if (clr_at_eof) begin
                    ctl_wr = 1'b1; ctl_wdata = {1'b1, ctl_cur};
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic wctl(input logic [4:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v; ctl_cur = v[3:0];
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset ctl_bits", 48'(ctl_bits), 48'h0);
        chk("R10 reset flag", 48'(wake_flag), 48'h0);
        chk("R9 reset irq", 48'(irq), 48'h0);
        rst_n = 1'b1;
        glb_ie = 1'b1;

        // frame table
        for (int v = 0; v < NV; v++) begin
            wctl({1'b1, VEC[v].relax, 3'b111});
            build(VEC[v].dest, VEC[v].nff, VEC[v].ncopy, VEC[v].bad, VEC[v].pre);
            send(VEC[v].good, 1'b1, 1'b0);
            chk($sformatf("vector %0d flag", v), 48'(wake_flag), 48'(VEC[v].hit));
            chk($sformatf("vector %0d irq", v), 48'(irq), 48'(VEC[v].hit));
        end

        // R7 flag rises in the cycle after the end byte
        wctl(5'b1_0111);
        build(2'd0, 4'd6, 5'd16, 8'd255, 1'b0);
        send(1'b1, 1'b1, 1'b0);
        chk("R7 flag during end byte", 48'(flag_at_eof), 48'h0);
        chk("R7 flag after end byte", 48'(wake_flag), 48'h1);

        // R8 write 0 keeps, set beats clear, write 1 clears
        wctl(5'b0_0111);
        chk("R8 write zero keeps flag", 48'(wake_flag), 48'h1);
        send(1'b1, 1'b1, 1'b1);
        chk("R8 set wins over clear", 48'(wake_flag), 48'h1);
        wctl(5'b1_0111);
        chk("R8 write one clears", 48'(wake_flag), 48'h0);

        // R9 interrupt gating
        send(1'b1, 1'b1, 1'b0);
        chk("R9 irq all enabled", 48'(irq), 48'h1);
        glb_ie = 1'b0; #1;
        chk("R9 irq global off", 48'(irq), 48'h0);
        glb_ie = 1'b1;
        wctl(5'b0_0011);
        chk("R9 irq enable off", 48'(irq), 48'h0);
        chk("R9 flag kept", 48'(wake_flag), 48'h1);
        wctl(5'b0_0111);
        chk("R9 irq enable on", 48'(irq), 48'h1);

        // R10 stop and software reset
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
        chk("R10 stop clears flag", 48'(wake_flag), 48'h0);
        chk("R10 stop keeps bits", 48'(ctl_bits), 48'h7);
        wctl(5'b0_1111);
        @(negedge clk); sw_reset = 1'b1;
        @(negedge clk); sw_reset = 1'b0;
        chk("R10 sw reset clears bits", 48'(ctl_bits), 48'h0);

        // R6 and R11 mode entry
        wctl(5'b1_0010);
        chk("R6 mode bit alone", 48'(mode_active), 48'h0);
        send(1'b1, 1'b1, 1'b0);
        chk("R11 no detection when idle", 48'(wake_flag), 48'h0);
        pwr_good = 1'b1; #1;
        chk("R6 mode with power good", 48'(mode_active), 48'h1);
        send(1'b1, 1'b1, 1'b0);
        chk("R6 detection with power good", 48'(wake_flag), 48'h1);
        wctl(5'b1_0001);
        chk("R6 enable without mode", 48'(mode_active), 48'h0);
        pwr_good = 1'b0;
        wctl(5'b1_0011);
        chk("R6 enable and mode", 48'(mode_active), 48'h1);

        // R2 second relaxed-address bit
        wctl(5'b1_0111);
        relax_ext = 1'b1;
        build(2'd2, 4'd6, 5'd16, 8'd255, 1'b0);
        send(1'b1, 1'b1, 1'b0);
        chk("R2 external relax bit", 48'(wake_flag), 48'h1);
        relax_ext = 1'b0;

        // R5 restart in mid-frame discards a complete match
        wctl(5'b1_0111);
        build(2'd0, 4'd6, 5'd16, 8'd255, 1'b0);
        send(1'b1, 1'b0, 1'b0);
        build(2'd0, 4'd0, 5'd0, 8'd255, 1'b0);
        send(1'b1, 1'b1, 1'b0);
        chk("R5 restart discards match", 48'(wake_flag), 48'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule